// File: doc/BRIEF.md
# Programmable Reference Divider and Phase-Frequency Detector

This block divides a fast reference clock by a programmable integer ratio and compares the divided reference against the divided oscillator feedback, one cycle-wide edge each. A three-state phase-frequency detector turns the order in which the two edges arrive into a pump-up and a pump-down request for a downstream charge pump.

A sense control exchanges the two requests so that one loop design can steer an oscillator whose frequency rises with tuning voltage as well as one whose frequency falls. The ratio is normally the reference frequency over the wanted comparison frequency. For example, a 4 MHz reference needs a ratio of 64 for 62.5 kHz and 16 for 250 kHz.

Everything runs in the reference clock domain. The feedback edge arrives as a one-cycle pulse that is already synchronous to that clock.

Top module: `refpfd_top`

## Requirements
- R1: While `rst` is high, `ref_pulse_out`, `pump_up_out` and `pump_dn_out` are all 0 from the first clock edge onward.
- R2: For a ratio R with 3 <= R <= 32767, `ref_pulse_out` is high for exactly one cycle out of every R clock cycles.
- R3: A programmed ratio of 0, 1 or 2 acts as a ratio of 3, so two reference pulses are always at least 3 cycles apart.
- R4: The ratio is sampled only in the cycle that produces a reference pulse. A change to `ratio_in` therefore leaves the period in progress at its old length, and the new ratio sets the length of the following period.
- R5: With `polarity_in` = 0 and a feedback pulse that lags the reference pulse by d cycles, `pump_up_out` is high for d+1 cycles and `pump_dn_out` is high for 1 cycle.
- R6: With `polarity_in` = 0 and a feedback pulse that leads the reference pulse by d cycles, `pump_dn_out` is high for d+1 cycles and `pump_up_out` is high for 1 cycle.
- R7: With `polarity_in` = 1 (an oscillator with negative tuning slope), the pump-up and pump-down widths of R5 and R6 are exchanged.
- R8: When both internal requests are set, both clear on the next clock. Both pump outputs are therefore never high together for more than one cycle, and coincident edges give a 1-cycle pulse on each output.
- R9: The request that an edge produces appears on the pump outputs 2 clocks after the reference pulse cycle. With positive sense, a rising `pump_up_out` is always preceded by a reference pulse 2 cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_in | input | 15 | Reference division ratio; values below 3 act as 3 |
| polarity_in | input | 1 | Detector sense: 0 positive slope, 1 negative slope |
| fb_pulse_in | input | 1 | One-cycle pulse marking a divided feedback edge |
| ref_pulse_out | output | 1 | One-cycle pulse marking a divided reference edge |
| pump_up_out | output | 1 | Registered pump-up request |
| pump_dn_out | output | 1 | Registered pump-down request |

## Verification
The bench targets the following failure modes:
- Off-by-one reload in the counter, which would make every period one cycle long or short, most visibly at the clamped ratios 0 to 2 and at the largest ratio.
- A ratio change written mid-period, which a design that reloads eagerly would apply one period too early.
- Leading and lagging feedback at several offsets under both senses; a swapped or missing exchange shows up as pump widths on the wrong output.
- Coincident edges, and the delay of two clocks from reference pulse to pump output. A detector whose reset path is slow or swallows an edge gives wrong pulse widths.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

  // Raw detector request pair, before any sense exchange.
  typedef struct packed {
    logic up;
    logic dn;
  } pump_pair_t;

  // Detector sense as chosen by the oscillator tuning slope.
  typedef enum logic {
    SENSE_POSITIVE = 1'b0,
    SENSE_NEGATIVE = 1'b1
  } sense_e;

endpackage

// File: rtl/refpfd_ratio_counter.sv
module refpfd_ratio_counter #(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               tick_out
);

  localparam logic [RATIO_W-1:0] MIN_VAL = RATIO_W'(MIN_RATIO);
  localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);

  logic [RATIO_W-1:0] eff_ratio;
  logic [RATIO_W-1:0] remain_q;

  // Ratios under the floor are raised to it.
  always_comb begin
    eff_ratio = (ratio_in < MIN_VAL) ? MIN_VAL : ratio_in;
  end

  // Count down to zero; on zero emit a tick and reload from the
  // ratio presented in that same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      tick_out <= 1'b0;
    end else if (remain_q == '0) begin
      remain_q <= eff_ratio - ONE;
      tick_out <= 1'b1;
    end else begin
      remain_q <= remain_q - ONE;
      tick_out <= 1'b0;
    end
  end

endmodule

// File: rtl/refpfd_phase_detector.sv
module refpfd_phase_detector
  import refpfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_edge,
  input  logic       fb_edge,
  output pump_pair_t req_out
);

  logic up_q;
  logic dn_q;
  logic both_set;

  // Both requests set means the later edge has arrived: clear both
  // on the next clock, but keep an edge that lands in that cycle.
  always_comb begin
    both_set = up_q & dn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both_set) begin
      up_q <= ref_edge;
      dn_q <= fb_edge;
    end else begin
      up_q <= up_q | ref_edge;
      dn_q <= dn_q | fb_edge;
    end
  end

  always_comb begin
    req_out.up = up_q;
    req_out.dn = dn_q;
  end

endmodule

// File: rtl/refpfd_sense_swap.sv
module refpfd_sense_swap
  import refpfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pump_pair_t req_in,
  input  logic       sense_in,
  output logic       pump_up_out,
  output logic       pump_dn_out
);

  sense_e     sense;
  pump_pair_t steered;

  always_comb begin
    sense = sense_e'(sense_in);
    if (sense == SENSE_NEGATIVE) begin
      steered.up = req_in.dn;
      steered.dn = req_in.up;
    end else begin
      steered = req_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up_out <= 1'b0;
      pump_dn_out <= 1'b0;
    end else begin
      pump_up_out <= steered.up;
      pump_dn_out <= steered.dn;
    end
  end

endmodule

// File: rtl/refpfd_top.sv
module refpfd_top
  import refpfd_pkg::*;
#(
  parameter int RATIO_W   = 15,
  parameter int MIN_RATIO = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               polarity_in,
  input  logic               fb_pulse_in,
  output logic               ref_pulse_out,
  output logic               pump_up_out,
  output logic               pump_dn_out
);

  pump_pair_t raw_req;

  refpfd_ratio_counter #(
    .RATIO_W  (RATIO_W),
    .MIN_RATIO(MIN_RATIO)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .ratio_in(ratio_in),
    .tick_out(ref_pulse_out)
  );

  refpfd_phase_detector u_detector (
    .clk     (clk),
    .rst     (rst),
    .ref_edge(ref_pulse_out),
    .fb_edge (fb_pulse_in),
    .req_out (raw_req)
  );

  refpfd_sense_swap u_swap (
    .clk        (clk),
    .rst        (rst),
    .req_in     (raw_req),
    .sense_in   (polarity_in),
    .pump_up_out(pump_up_out),
    .pump_dn_out(pump_dn_out)
  );

endmodule

// File: rtl/refpfd_checker.sv
module refpfd_checker (
  input logic clk,
  input logic rst,
  input logic polarity_in,
  input logic fb_pulse_in,
  input logic ref_pulse_out,
  input logic pump_up_out,
  input logic pump_dn_out
);

  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
  end

  // R1: one edge into reset, every output is low
  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_quiet_in_reset_r1: assert (!ref_pulse_out && !pump_up_out && !pump_dn_out)
        else $error("outputs active during reset");
    end
  end

  // R3: reference pulses are single and at least three cycles apart
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    ref_pulse_out |-> (!$past(ref_pulse_out) && !$past(ref_pulse_out, 2)));

  // R8: the two pump outputs overlap for at most one cycle
  p_overlap_once_r8: assert property (@(posedge clk) disable iff (rst)
    (pump_up_out && pump_dn_out) |=> !(pump_up_out && pump_dn_out));

  // R9: with positive sense a pump-up rise follows a reference pulse by two clocks
  p_up_cause_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(pump_up_out) && !$past(polarity_in) && !$past(polarity_in, 2))
      |-> $past(ref_pulse_out, 2));

  // R7: with negative sense the reference edge drives pump-down instead
  p_dn_cause_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(pump_dn_out) && $past(polarity_in) && $past(polarity_in, 2))
      |-> $past(ref_pulse_out, 2));

endmodule

bind refpfd_top refpfd_checker u_refpfd_checker (
  .clk          (clk),
  .rst          (rst),
  .polarity_in  (polarity_in),
  .fb_pulse_in  (fb_pulse_in),
  .ref_pulse_out(ref_pulse_out),
  .pump_up_out  (pump_up_out),
  .pump_dn_out  (pump_dn_out)
);

// File: tb/refpfd_top_bench.sv
module refpfd_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] ratio_in = 15'd64;
  logic        polarity_in = 1'b0;
  logic        fb_pulse_in = 1'b0;
  logic        ref_pulse_out;
  logic        pump_up_out;
  logic        pump_dn_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  refpfd_top u_refpfd_top (
    .clk          (clk),
    .rst          (rst),
    .ratio_in     (ratio_in),
    .polarity_in  (polarity_in),
    .fb_pulse_in  (fb_pulse_in),
    .ref_pulse_out(ref_pulse_out),
    .pump_up_out  (pump_up_out),
    .pump_dn_out  (pump_dn_out)
  );

  function automatic int clamp_ratio(int r);
    return (r < 3) ? 3 : r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!ref_pulse_out);
  endtask

  task automatic count_to_tick(output int p);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!ref_pulse_out);
  endtask

  task automatic check_period(int r, string req);
    int p;
    ratio_in = 15'(r);
    wait_tick();
    count_to_tick(p);
    check(req, p, clamp_ratio(r));
  endtask

  // Sync on a reference pulse, paired with a feedback pulse to flush any
  // pending request, then place one feedback pulse d cycles before (lead)
  // or after (lag) the next reference pulse and count the pump widths.
  task automatic run_pfd(bit pol, bit lead, int d, int r);
    int  up_n = 0;
    int  dn_n = 0;
    int  first_win = -1000;
    int  total;
    bit  swapped;
    logic win_out;
    polarity_in = pol;
    wait_tick();
    fb_pulse_in = 1'b1;
    total = r + d + 6;
    swapped = pol ^ lead;
    for (int c = 1; c <= total; c++) begin
      @(negedge clk);
      if (c >= 4) begin
        if (pump_up_out) up_n++;
        if (pump_dn_out) dn_n++;
        win_out = swapped ? pump_dn_out : pump_up_out;
        if (win_out && first_win == -1000) first_win = c - r;
      end
      fb_pulse_in = lead ? (c == r - d) : (c == r + d);
    end
    fb_pulse_in = 1'b0;
    if (d == 0) begin
      check("R8 coincident up width", up_n, 1);
      check("R8 coincident dn width", dn_n, 1);
    end else if (!pol) begin
      check(lead ? "R6 up width" : "R5 up width", up_n, swapped ? 1 : d + 1);
      check(lead ? "R6 dn width" : "R5 dn width", dn_n, swapped ? d + 1 : 1);
    end else begin
      check("R7 up width", up_n, swapped ? 1 : d + 1);
      check("R7 dn width", dn_n, swapped ? d + 1 : 1);
    end
    if (!lead) check("R9 edge to pump latency", first_win, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int p0;
    int p1;
    int r;
    int d;
    seed = $urandom(32'h5eed_1234);

    // R1: quiet outputs while reset is held
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check("R1 ref in reset", int'(ref_pulse_out), 0);
      check("R1 up in reset", int'(pump_up_out), 0);
      check("R1 dn in reset", int'(pump_dn_out), 0);
      @(negedge clk);
    end
    rst = 1'b0;

    // R2: directed ratios
    check_period(64, "R2 period 64");
    check_period(16, "R2 period 16");
    check_period(5, "R2 period 5");
    check_period(3, "R2 period 3");
    check_period(32767, "R2 period 32767");

    // R3: ratios under the floor
    check_period(0, "R3 ratio 0");
    check_period(1, "R3 ratio 1");
    check_period(2, "R3 ratio 2");

    // R4: change in mid-period takes effect one period later
    ratio_in = 15'd40;
    wait_tick();
    wait_tick();
    ratio_in = 15'd25;
    count_to_tick(p0);
    count_to_tick(p1);
    check("R4 period in progress keeps old ratio", p0, 40);
    check("R4 next period uses new ratio", p1, 25);

    // R2/R3: random ratios
    for (int i = 0; i < 12; i++) begin
      r = int'($urandom_range(0, 300));
      check_period(r, (r < 3) ? "R3 random ratio" : "R2 random ratio");
    end

    // Directed detector cases
    ratio_in = 15'd64;
    wait_tick();
    run_pfd(1'b0, 1'b0, 3, 64);
    run_pfd(1'b0, 1'b1, 5, 64);
    run_pfd(1'b1, 1'b0, 4, 64);
    run_pfd(1'b1, 1'b1, 2, 64);
    run_pfd(1'b0, 1'b0, 0, 64);
    run_pfd(1'b1, 1'b0, 0, 64);
    run_pfd(1'b0, 1'b0, 57, 64);
    run_pfd(1'b0, 1'b1, 59, 64);

    // Random detector cases
    for (int i = 0; i < 30; i++) begin
      r = int'($urandom_range(20, 150));
      d = int'($urandom_range(0, r - 7));
      ratio_in = 15'(r);
      wait_tick();
      wait_tick();
      run_pfd(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, r);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule